// File: doc/BRIEF.md
# Image Pyramid Reduction Filter

This block produces the next coarser level of an image pyramid from a raster-scanned input level. Pixels arrive one at a time with markers for the first pixel of a frame, the last pixel of each line and the last pixel of the frame. For every input pixel whose column and row are both even, the block takes the 3x3 neighbourhood around it and forms a weighted average: the centre counts four times, the four edge-adjacent neighbours twice and the four corners once. Each weight is a power of two, so the block builds the sum from shifts and adds and then divides by sixteen. The output stream is half as wide and half as tall as the input, and it carries its own frame and line markers. Further levels come from chaining instances in series.

Two internal row stores hold the two most recent complete lines. A three-column register window holds the columns already seen in the current line. Each input pixel is therefore read once, and every overlapping mask is served from local storage. The mask centred on an even pixel is complete when the pixel one row below and one column to the right arrives, and the result appears on the next clock edge. On the top row the missing row above is taken from row 0, and on the left column the missing column is taken from column 0.

Frames must have an even width of at most `MAX_W` and an even height.

Top module: `pyr_reduce`

## Requirements
- R1: While `rst_n` is low, and until the first qualifying input pixel after it rises, `out_valid`, `out_sof`, `out_eol` and `out_eof` are 0.
- R2: For a W x H input frame (W and H even, W <= `MAX_W`), exactly (W/2)*(H/2) outputs are produced in raster order. Each output appears one clock after the input pixel at odd column 2i+1 and odd row 2j+1 is accepted, and it belongs to output position (i, j).
- R3: The output at (i, j) equals (S + 8) >> 4 when `ROUND`=1, or S >> 4 when `ROUND`=0. S is the sum over the 3x3 mask centred on input (2i, 2j): the centre pixel times 4, the four edge-adjacent pixels times 2 and the four corner pixels times 1.
- R4: For output row j = 0, the mask row above the centre uses input row 0.
- R5: For output column i = 0, the mask column left of the centre uses input column 0.
- R6: Idle cycles (`in_valid` = 0) inserted anywhere in the stream change neither the output values nor their order.
- R7: `out_sof` is 1 exactly on output (0,0). `out_eol` is 1 exactly on the last output of each output row. `out_eof` is 1 exactly on the last output of the frame. All three are 0 whenever `out_valid` is 0.
- R8: An `in_sof` pixel restarts the column and row count at (0,0), even when the previous frame was not finished, and the new frame is filtered as if no earlier frame had arrived.
- R9: `out_valid` is never 1 on two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present this cycle |
| in_data | input | DATA_W | Input pixel value |
| in_sof | input | 1 | Marks the first pixel of a frame (column 0, row 0) |
| in_eol | input | 1 | Marks the last pixel of a line |
| in_eof | input | 1 | Marks the last pixel of a frame |
| out_valid | output | 1 | Reduced pixel present this cycle |
| out_data | output | DATA_W | Reduced pixel value |
| out_sof | output | 1 | First reduced pixel of the frame |
| out_eol | output | 1 | Last reduced pixel of an output row |
| out_eof | output | 1 | Last reduced pixel of the frame |

## Verification
The hardest case to reach from the ports is a frame start that arrives while the row stores and the column window still hold data from an unfinished frame. If the restart were handled wrongly, stale rows or columns would leak into the first masks of the new frame. The bench therefore sends three rows of one pattern without an end marker and then starts a frame with a different pattern. Every output of that frame must match the replicated-border reference, including the top row, whose upper mask row must come from the new row 0 and not from a stored row. The same frames are also sent with idle cycles scattered between pixels, so that window shifts happen with gaps between them.

// File: rtl/pyr_reduce_pkg.sv
package pyr_reduce_pkg;

   // mask geometry and normalisation
   localparam int unsigned MASK_N     = 3;
   localparam int unsigned NORM_SHIFT = 4;

   // weight exponent of a mask tap: centre 2, edge 1, corner 0
   function automatic int unsigned tap_shift(input int unsigned r, input int unsigned c);
      return ((r == 1) ? 1 : 0) + ((c == 1) ? 1 : 0);
   endfunction

endpackage

// File: rtl/pyr_row_store.sv
module pyr_row_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   // read returns the previous line's value at this column before the write
   assign rd_data = mem[addr];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= wr_data;
      end
   end

   // a_r2_addr_in_range: the column index stays inside the row store
   always_ff @(posedge clk) begin
      if (wr_en) begin
         a_r2_addr_in_range: assert (int'(addr) < int'(DEPTH))
            else $error("row store address %0d out of range", addr);
      end
   end

endmodule

// File: rtl/pyr_col_window.sv
module pyr_col_window #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned N     = pyr_reduce_pkg::MASK_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              left_rep_i,
   input  logic [DATA_W-1:0] col_i [N],
   output logic [DATA_W-1:0] win_o [N][N]
);

   logic [DATA_W-1:0] prev1 [N];
   logic [DATA_W-1:0] prev2 [N];

   genvar r;
   generate
      for (r = 0; r < N; r++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev1[r] <= '0;
               prev2[r] <= '0;
            end else if (shift_i) begin
               prev2[r] <= prev1[r];
               prev1[r] <= col_i[r];
            end
         end
         // left column replicates column 0 when the centre sits on column 0
         assign win_o[r][0] = left_rep_i ? prev1[r] : prev2[r];
         assign win_o[r][1] = prev1[r];
         assign win_o[r][2] = col_i[r];
      end
   endgenerate

endmodule

// File: rtl/pyr_kernel.sv
module pyr_kernel #(
   parameter int unsigned DATA_W = 8,
   parameter bit          ROUND  = 1'b1,
   localparam int unsigned N     = pyr_reduce_pkg::MASK_N,
   localparam int unsigned SH    = pyr_reduce_pkg::NORM_SHIFT,
   localparam int unsigned SW    = DATA_W + SH
) (
   input  logic [DATA_W-1:0] win_i [N][N],
   output logic [DATA_W-1:0] pix_o
);
   import pyr_reduce_pkg::*;

   logic [SW-1:0] acc;
   logic [SW-1:0] biased;

   always_comb begin
      acc = '0;
      for (int unsigned r = 0; r < N; r++) begin
         for (int unsigned c = 0; c < N; c++) begin
            acc = acc + (SW'(win_i[r][c]) << tap_shift(r, c));
         end
      end
   end

   generate
      if (ROUND) begin : g_round
         assign biased = acc + SW'(1 << (SH - 1));
      end else begin : g_trunc
         assign biased = acc;
      end
   endgenerate

   assign pix_o = biased[SW-1:SH];

endmodule

// File: rtl/pyr_reduce.sv
module pyr_reduce #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MAX_W  = 16,
   parameter int unsigned MAX_H  = 16,
   parameter bit          ROUND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic              in_eof,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eol,
   output logic              out_eof
);
   import pyr_reduce_pkg::*;

   localparam int unsigned N      = MASK_N;
   localparam int unsigned XW     = (MAX_W > 1) ? $clog2(MAX_W) : 1;
   localparam int unsigned YW     = (MAX_H > 2) ? $clog2(MAX_H) : 2;
   localparam int unsigned NSTORE = N - 1;

   initial begin
      a_param_width: assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      a_param_maxw:  assert (MAX_W >= 2 && MAX_W % 2 == 0) else $error("MAX_W must be even and >= 2");
      a_param_maxh:  assert (MAX_H >= 2) else $error("MAX_H must be at least 2");
   end

   // ---------------- position tracking ----------------
   logic [XW-1:0] x_cnt, cur_x;
   logic [YW-1:0] y_cnt, cur_y;

   assign cur_x = in_sof ? '0 : x_cnt;
   assign cur_y = in_sof ? '0 : y_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_cnt <= '0;
         y_cnt <= '0;
      end else if (in_valid) begin
         if (in_eol) begin
            x_cnt <= '0;
            y_cnt <= cur_y + YW'(1);
         end else begin
            x_cnt <= cur_x + XW'(1);
            y_cnt <= cur_y;
         end
      end
   end

   // ---------------- row stores (chained) ----------------
   logic [DATA_W-1:0] st_wr [NSTORE];
   logic [DATA_W-1:0] st_rd [NSTORE];

   genvar k;
   generate
      for (k = 0; k < NSTORE; k++) begin : g_store
         if (k == 0) begin : g_head
            assign st_wr[k] = in_data;
         end else begin : g_tail
            assign st_wr[k] = st_rd[k-1];
         end
         pyr_row_store #(
            .DATA_W (DATA_W),
            .DEPTH  (MAX_W)
         ) u_store (
            .clk     (clk),
            .wr_en   (in_valid),
            .addr    (cur_x),
            .wr_data (st_wr[k]),
            .rd_data (st_rd[k])
         );
      end
   endgenerate

   // ---------------- column assembly with top replication ----------------
   logic [DATA_W-1:0] col [N];
   logic              top_rep;

   assign top_rep = (cur_y == YW'(1));
   assign col[2]  = in_data;
   assign col[1]  = st_rd[0];
   assign col[0]  = top_rep ? st_rd[0] : st_rd[NSTORE-1];

   // ---------------- window and kernel ----------------
   logic [DATA_W-1:0] win [N][N];
   logic [DATA_W-1:0] kern;
   logic              left_rep;

   assign left_rep = (cur_x == XW'(1));

   pyr_col_window #(
      .DATA_W (DATA_W)
   ) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (in_valid),
      .left_rep_i (left_rep),
      .col_i      (col),
      .win_o      (win)
   );

   pyr_kernel #(
      .DATA_W (DATA_W),
      .ROUND  (ROUND)
   ) u_kernel (
      .win_i (win),
      .pix_o (kern)
   );

   // ---------------- output stage ----------------
   logic fire;
   assign fire = in_valid & cur_x[0] & cur_y[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_eof   <= 1'b0;
      end else begin
         out_valid <= fire;
         out_sof   <= fire & top_rep & left_rep;
         out_eol   <= fire & in_eol;
         out_eof   <= fire & in_eof;
         if (fire) begin
            out_data <= kern;
         end
      end
   end

   // ---------------- assertions ----------------
   logic [DATA_W-1:0] win_min, win_max;
   always_comb begin
      win_min = win[0][0];
      win_max = win[0][0];
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            if (win[r][c] < win_min) win_min = win[r][c];
            if (win[r][c] > win_max) win_max = win[r][c];
         end
      end
   end

   // a_r3_within_window: a normalised weighted average stays inside the mask range
   always_ff @(posedge clk) begin
      if (rst_n && fire) begin
         a_r3_within_window: assert (kern >= win_min && kern <= win_max)
            else $error("kernel result %0d outside [%0d,%0d]", kern, win_min, win_max);
      end
   end

   a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r2_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   a_r7_markers_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eol || out_eof) |-> out_valid);

   a_r7_eof_needs_input_eof: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> $past(in_eof));

endmodule

// File: tb/pyr_reduce_bench.sv
module pyr_reduce_bench;

   localparam int DW    = 8;
   localparam int MAXW  = 16;
   localparam int NOUT  = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_sof, out_eol, out_eof;

   always #4 clk = ~clk;   // 125 MHz

   pyr_reduce #(.DATA_W(DW), .MAX_W(MAXW), .MAX_H(16), .ROUND(1'b1)) u_pyr_reduce (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data),
      .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
      .out_valid(out_valid), .out_data(out_data),
      .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof)
   );

   int n_checks = 0;
   int n_errors = 0;

   // captured outputs
   logic [DW-1:0] got_d   [NOUT];
   logic          got_sof [NOUT];
   logic          got_eol [NOUT];
   logic          got_eof [NOUT];
   int            n_got = 0;
   int            n_b2b = 0;
   logic          prev_v = 1'b0;

   always @(negedge clk) begin
      if (out_valid) begin
         if (n_got < NOUT) begin
            got_d[n_got]   = out_data;
            got_sof[n_got] = out_sof;
            got_eol[n_got] = out_eol;
            got_eof[n_got] = out_eof;
         end
         n_got++;
         if (prev_v) n_b2b++;
      end
      prev_v = out_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int pix(input int x, input int y, input int seed);
      if (seed == 3) return ((x + y) % 2 == 1) ? 255 : 0;
      return (x * 29 + y * 53 + seed * 71 + x * y * 7 + (x ^ y) * 11) % 256;
   endfunction

   function automatic int expect_pix(input int ox, input int oy, input int seed);
      int s;
      s = 0;
      for (int dy = -1; dy <= 1; dy++) begin
         for (int dx = -1; dx <= 1; dx++) begin
            int xx, yy, w;
            xx = 2 * ox + dx; if (xx < 0) xx = 0;
            yy = 2 * oy + dy; if (yy < 0) yy = 0;
            w  = ((dx == 0) ? 2 : 1) * ((dy == 0) ? 2 : 1);
            s  = s + w * pix(xx, yy, seed);
         end
      end
      return (s + 8) >> 4;
   endfunction

   task automatic send_pixels(input int w, input int h, input int seed, input bit gaps, input bit last);
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(pix(x, y, seed));
            in_sof   = (x == 0 && y == 0);
            in_eol   = (x == w - 1);
            in_eof   = last && (x == w - 1) && (y == h - 1);
            if (gaps && ((x + y) % 3 == 0)) begin
               @(negedge clk);
               in_valid = 1'b0;
               in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_frame(input int w, input int h, input int seed, input string tag);
      int ow, oh;
      ow = w / 2; oh = h / 2;
      chk(n_got == ow * oh, {tag, " R2 output count"}, n_got, ow * oh);
      chk(n_b2b == 0, {tag, " R9 back-to-back valid"}, n_b2b, 0);
      for (int i = 0; i < ow * oh && i < NOUT; i++) begin
         int ox, oy, e;
         string req;
         ox = i % ow; oy = i / ow;
         e  = expect_pix(ox, oy, seed);
         req = (oy == 0) ? "R4 top row" : ((ox == 0) ? "R5 left column" : "R3 value");
         chk(int'(got_d[i]) == e, {tag, " ", req}, int'(got_d[i]), e);
         chk(got_sof[i] == (i == 0), {tag, " R7 sof"}, int'(got_sof[i]), int'(i == 0));
         chk(got_eol[i] == (ox == ow - 1), {tag, " R7 eol"}, int'(got_eol[i]), int'(ox == ow - 1));
         chk(got_eof[i] == (i == ow * oh - 1), {tag, " R7 eof"}, int'(got_eof[i]), int'(i == ow * oh - 1));
      end
      n_got = 0;
      n_b2b = 0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      chk({out_sof, out_eol, out_eof} == 3'b000, "R1 markers in reset", int'({out_sof, out_eol, out_eof}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      n_got = 0; n_b2b = 0;
   endtask

   task automatic t_basic;
      send_pixels(8, 6, 0, 1'b0, 1'b1);
      check_frame(8, 6, 0, "basic 8x6");
   endtask

   task automatic t_max_width;
      send_pixels(MAXW, 4, 1, 1'b0, 1'b1);
      check_frame(MAXW, 4, 1, "max width");
   endtask

   task automatic t_minimal;
      send_pixels(2, 2, 2, 1'b0, 1'b1);
      check_frame(2, 2, 2, "2x2 R4 R5");
   endtask

   task automatic t_checker;
      send_pixels(6, 4, 3, 1'b0, 1'b1);
      check_frame(6, 4, 3, "checker rounding R3");
   endtask

   task automatic t_gaps;
      send_pixels(8, 6, 0, 1'b1, 1'b1);
      check_frame(8, 6, 0, "R6 idle gaps");
   endtask

   task automatic t_resync;
      send_pixels(8, 3, 2, 1'b0, 1'b0);
      n_got = 0; n_b2b = 0;
      send_pixels(8, 4, 4, 1'b1, 1'b1);
      check_frame(8, 4, 4, "R8 restart");
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_basic();
      t_max_width();
      t_minimal();
      t_checker();
      t_gaps();
      t_resync();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule